// File: doc/BRIEF.md
# Keyboard Lock-Indicator Command Sender

This block is the host end of a two-wire, open-drain keyboard link, used only to set the keyboard's three lock indicators. When it accepts a request carrying a 3-bit indicator value, it takes the bus by holding the clock line low. It then issues a start bit and releases the clock. The keyboard clocks out the set-indicators command byte ED, and the host checks the keyboard's acknowledge bit at the end of the frame.

Once ED is acknowledged, the block releases both lines. It then waits for the keyboard's reply byte FA, which reaches it from a separate receive path as a byte with a valid strobe. On FA it takes the bus again and sends the indicator byte. A one-cycle done strobe marks success. A one-cycle error strobe marks a missing reply, a missing acknowledge bit or a stalled frame. Either strobe returns the block to idle with both lines released.

The block never drives a line high. Each line has a pull-down enable (1 = pull low), and the real line level is read back through a two-stage synchroniser. Outgoing bits change on falling edges of the clock that the keyboard generates.

Top module: `kbd_led_cmd`

## Requirements
- R1: After reset, both pull-down enables, busy, done and err are 0.
- R2: A request seen while busy is 0 raises busy on the next cycle. The clock pull-down is then held for at least INHIBIT_CYC cycles. The data pull-down is asserted before the clock pull-down is released, and that low data level is the start bit.
- R3: Each frame places, on successive device-clock falling edges, eight data bits least-significant first, then an odd parity bit, then a stop bit of 1 (data released).
- R4: On the 11th device-clock falling edge of a frame, the data line must be low (the acknowledge). If it is high, err pulses and the block returns to idle.
- R5: The first frame carries the byte ED. After it is acknowledged, both lines are released while the block waits for a received byte equal to FA. Any other received byte is ignored.
- R6: If FA is not received within REPLY_CYC cycles of the first acknowledge, err pulses, the block goes idle and no second frame is sent.
- R7: After FA, the second frame carries bit 0 = Scroll Lock = led_val[0], bit 1 = Num Lock = led_val[1] and bit 2 = Caps Lock = led_val[2]. Bits 3 to 7 are 0.
- R8: A done pulse of exactly one cycle follows the acknowledge of the second frame, and busy is already 0 in that cycle. done and err are never high together.
- R9: A request that arrives while busy is 1 is ignored. The indicator value sent is the one captured when the sequence was accepted.
- R10: If a frame has not been acknowledged within REPLY_CYC cycles of the clock release, err pulses and the block goes idle.
- R11: While busy is 0, both pull-down enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start an indicator update |
| led_val | input | 3 | Indicator value: bit 0 scroll, bit 1 num, bit 2 caps |
| ps2_clk_in | input | 1 | Clock line level read back |
| ps2_dat_in | input | 1 | Data line level read back |
| rx_valid | input | 1 | A byte from the receive path is valid |
| rx_byte | input | 8 | Byte from the receive path |
| ps2_clk_oe | output | 1 | Clock line pull-down enable (1 = low) |
| ps2_dat_oe | output | 1 | Data line pull-down enable (1 = low) |
| busy | output | 1 | Command sequence in progress |
| done | output | 1 | One-cycle success strobe |
| err | output | 1 | One-cycle failure strobe |

## Verification
The bench builds the block with INHIBIT_CYC = 20 and REPLY_CYC = 2000 in place of the default microsecond and millisecond counts. This brings the inhibit hold, the reply timeout and the stalled-frame timeout within a few thousand cycles, so each can be measured against its exact bound. A bench keyboard model drives the wired-AND lines and decodes both frames. The bench runs all eight indicator values, and exercises a missing acknowledge bit, a missing reply, a foreign reply byte, a keyboard that never clocks and a request arriving mid-sequence.

// File: rtl/kbd_led_cmd.sv
module kbd_led_cmd #(
  parameter int INHIBIT_CYC = 5000,
  parameter int REPLY_CYC   = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic [2:0] led_val,
  input  logic       ps2_clk_in,
  input  logic       ps2_dat_in,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       ps2_clk_oe,
  output logic       ps2_dat_oe,
  output logic       busy,
  output logic       done,
  output logic       err
);
  localparam int TMAX = (REPLY_CYC > INHIBIT_CYC) ? REPLY_CYC : INHIBIT_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [7:0] CMD_SET = 8'hED;
  localparam logic [7:0] KB_ACK  = 8'hFA;

  typedef enum logic [2:0] {S_IDLE, S_HOLD, S_START, S_SEND, S_WAIT} st_t;

  st_t         st;
  logic [2:0]  ck_sy;
  logic [1:0]  dt_sy;
  logic [TW-1:0] tmr;
  logic [9:0]  sh;
  logic [3:0]  nbit;
  logic        second;
  logic [2:0]  mask;
  logic        fall;
  logic [7:0]  led_byte;

  assign fall     = ck_sy[2] & ~ck_sy[1];
  assign busy     = (st != S_IDLE);
  assign led_byte = {5'b0, mask};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      ck_sy      <= '1;
      dt_sy      <= '1;
      tmr        <= '0;
      sh         <= '0;
      nbit       <= '0;
      second     <= 1'b0;
      mask       <= '0;
      ps2_clk_oe <= 1'b0;
      ps2_dat_oe <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      done  <= 1'b0;
      err   <= 1'b0;
      ck_sy <= {ck_sy[1:0], ps2_clk_in};
      dt_sy <= {dt_sy[0], ps2_dat_in};
      case (st)
        S_IDLE: begin
          ps2_clk_oe <= 1'b0;
          ps2_dat_oe <= 1'b0;
          if (req) begin
            mask       <= led_val;
            second     <= 1'b0;
            sh         <= {1'b1, ~^CMD_SET, CMD_SET};
            nbit       <= '0;
            tmr        <= '0;
            ps2_clk_oe <= 1'b1;
            st         <= S_HOLD;
          end
        end
        S_HOLD: begin
          tmr <= tmr + TW'(1);
          if (tmr == TW'(INHIBIT_CYC - 1)) begin
            ps2_dat_oe <= 1'b1;
            st         <= S_START;
          end
        end
        S_START: begin
          ps2_clk_oe <= 1'b0;
          tmr        <= '0;
          st         <= S_SEND;
        end
        S_SEND: begin
          tmr <= tmr + TW'(1);
          if (tmr == TW'(REPLY_CYC - 1)) begin
            ps2_dat_oe <= 1'b0;
            err        <= 1'b1;
            st         <= S_IDLE;
          end else if (fall) begin
            if (nbit == 4'd10) begin
              ps2_dat_oe <= 1'b0;
              if (dt_sy[1]) begin
                err <= 1'b1;
                st  <= S_IDLE;
              end else if (second) begin
                done <= 1'b1;
                st   <= S_IDLE;
              end else begin
                tmr <= '0;
                st  <= S_WAIT;
              end
            end else begin
              ps2_dat_oe <= ~sh[0];
              sh         <= sh >> 1;
              nbit       <= nbit + 4'd1;
            end
          end
        end
        S_WAIT: begin
          tmr <= tmr + TW'(1);
          if (rx_valid && rx_byte == KB_ACK) begin
            second     <= 1'b1;
            sh         <= {1'b1, ~^led_byte, led_byte};
            nbit       <= '0;
            tmr        <= '0;
            ps2_clk_oe <= 1'b1;
            st         <= S_HOLD;
          end else if (tmr == TW'(REPLY_CYC - 1)) begin
            err <= 1'b1;
            st  <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/kbd_led_cmd_chk.sv
module kbd_led_cmd_chk #(
  parameter int INHIBIT_CYC = 5000
) (
  input logic clk,
  input logic rst_n,
  input logic req,
  input logic busy,
  input logic done,
  input logic err,
  input logic ps2_clk_oe,
  input logic ps2_dat_oe
);
  int run;

  always_ff @(posedge clk) begin
    if (!rst_n) run <= 0;
    else if (ps2_clk_oe) run <= (run < INHIBIT_CYC + 8) ? run + 1 : run;
    else run <= 0;
  end

  AST_REQ_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req) |=> busy); // R2
  AST_START_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ps2_clk_oe) |-> ps2_dat_oe); // R2
  AST_INHIBIT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ps2_clk_oe) |-> (run >= INHIBIT_CYC)); // R2
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ps2_clk_oe && !ps2_dat_oe)); // R11
endmodule

bind kbd_led_cmd kbd_led_cmd_chk #(.INHIBIT_CYC(INHIBIT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .done(done), .err(err),
  .ps2_clk_oe(ps2_clk_oe), .ps2_dat_oe(ps2_dat_oe)
);

// File: tb/sim_kbd_led_cmd.sv
`timescale 1ns/1ps
module sim_kbd_led_cmd;
  localparam int INH = 20;
  localparam int RPL = 2000;

  logic clk = 0, rst_n = 0, req = 0, rx_valid = 0;
  logic [2:0] led_val = 0;
  logic [7:0] rx_byte = 0;
  logic kb_clk = 1, kb_dat = 1;
  logic ps2_clk_in, ps2_dat_in, ps2_clk_oe, ps2_dat_oe, busy, done, err;

  assign ps2_clk_in = kb_clk & ~ps2_clk_oe;
  assign ps2_dat_in = kb_dat & ~ps2_dat_oe;

  always #5 clk = ~clk;

  kbd_led_cmd #(.INHIBIT_CYC(INH), .REPLY_CYC(RPL)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .led_val(led_val),
    .ps2_clk_in(ps2_clk_in), .ps2_dat_in(ps2_dat_in),
    .rx_valid(rx_valid), .rx_byte(rx_byte),
    .ps2_clk_oe(ps2_clk_oe), .ps2_dat_oe(ps2_dat_oe),
    .busy(busy), .done(done), .err(err));

  int checks = 0, errors = 0, n_done = 0, n_err = 0, done_busy = 0;
  bit finished = 0;

  always @(negedge clk) begin
    if (done) begin n_done++; if (busy) done_busy++; end
    if (err) n_err++;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_req(input logic [2:0] v);
    @(negedge clk); req = 1; led_val = v;
    @(negedge clk); req = 0;
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic kbd_frame(input bit ack, output logic [9:0] bits,
                           output int hold, output bit start_low);
    hold = 0;
    while (!ps2_clk_oe) @(negedge clk);
    while (ps2_clk_oe) begin hold++; @(negedge clk); end
    start_low = !ps2_dat_in;
    for (int i = 0; i < 10; i++) begin
      repeat (20) @(negedge clk); kb_clk = 0;
      repeat (40) @(negedge clk); kb_clk = 1;
      repeat (5) @(negedge clk); bits[i] = ps2_dat_in;
    end
    repeat (20) @(negedge clk); kb_dat = ack ? 1'b0 : 1'b1;
    repeat (5) @(negedge clk); kb_clk = 0;
    repeat (40) @(negedge clk); kb_clk = 1;
    repeat (5) @(negedge clk); kb_dat = 1;
  endtask

  task automatic chk_frame(input logic [9:0] b, input logic [7:0] exp, input string rq);
    chk(b[7:0] == exp, rq, b[7:0], exp);
    chk(^b[8:0] == 1'b1, "R3 odd parity", b[8:0], 0);
    chk(b[9] == 1'b1, "R3 stop bit", b[9], 1);
  endtask

  task automatic wait_idle(input int lim);
    for (int i = 0; i < lim && busy; i++) @(negedge clk);
  endtask

  initial begin
    logic [9:0] bits;
    int hold, d0, e0, cnt;
    bit sl;
    repeat (3) @(negedge clk);
    chk(!ps2_clk_oe && !ps2_dat_oe && !busy && !done && !err, "R1 reset outputs",
        {ps2_clk_oe, ps2_dat_oe, busy, done, err}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      d0 = n_done; e0 = n_err;
      do_req(3'(v));
      chk(busy == 1, "R2 busy after request", busy, 1);
      kbd_frame(1, bits, hold, sl);
      chk(hold >= INH, "R2 inhibit length", hold, INH);
      chk(sl, "R2 start bit low at release", sl, 1);
      chk_frame(bits, 8'hED, "R5 first byte");
      chk(!ps2_clk_oe && !ps2_dat_oe && busy, "R5 lines released while waiting",
          {ps2_clk_oe, ps2_dat_oe, busy}, 1);
      if (v == 3) begin
        do_req(3'd4);
        rx_send(8'h1C);
      end
      rx_send(8'hFA);
      kbd_frame(1, bits, hold, sl);
      chk_frame(bits, 8'(v), v == 3 ? "R9 value kept" : "R7 indicator byte");
      wait_idle(100);
      chk(n_done == d0 + 1, "R8 one done", n_done - d0, 1);
      chk(n_err == e0, "R8 no err on success", n_err - e0, 0);
      chk(!busy && !ps2_clk_oe && !ps2_dat_oe, "R11 idle released",
          {busy, ps2_clk_oe, ps2_dat_oe}, 0);
    end
    chk(done_busy == 0, "R8 busy low on done", done_busy, 0);

    // R6 missing reply
    d0 = n_done; e0 = n_err;
    do_req(3'd5);
    kbd_frame(1, bits, hold, sl);
    cnt = 0;
    while (n_err == e0 && cnt < RPL + 100) begin cnt++; @(negedge clk); end
    chk(n_err == e0 + 1, "R6 timeout err", n_err - e0, 1);
    chk(cnt >= RPL - 60 && cnt <= RPL - 20, "R6 timeout window", cnt, RPL - 40);
    chk(!busy && n_done == d0, "R6 idle, no done", {busy, 8'(n_done - d0)}, 0);
    repeat (300) @(negedge clk);
    chk(!ps2_clk_oe && !ps2_dat_oe, "R6 no second frame", {ps2_clk_oe, ps2_dat_oe}, 0);

    // R4 missing acknowledge bit
    e0 = n_err;
    do_req(3'd2);
    kbd_frame(0, bits, hold, sl);
    chk(n_err == e0 + 1, "R4 nack err", n_err - e0, 1);
    chk(!busy, "R4 idle after nack", busy, 0);

    // R10 keyboard never clocks
    e0 = n_err;
    do_req(3'd1);
    while (ps2_clk_oe) @(negedge clk);
    cnt = 0;
    while (n_err == e0 && cnt < RPL + 100) begin cnt++; @(negedge clk); end
    chk(n_err == e0 + 1, "R10 stall err", n_err - e0, 1);
    chk(cnt >= RPL - 5 && cnt <= RPL + 5, "R10 stall window", cnt, RPL);
    chk(!busy && !ps2_dat_oe, "R10 released", {busy, ps2_dat_oe}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule